// File: doc/BRIEF.md
# Converter Start-up and Auto-restart Supervisor

This block is the sequencing core of an off-line switching converter controller. It reads synchronous comparator flags for the supply rail, the high-voltage input, brown-out, thermal state and the fault latch. From these it decides three things: when the high-voltage start-up current source may charge the supply capacitor, which charge current is used, and when the PWM stage may switch. Each time switching begins, it also produces a current-limit reference code that ramps from zero to full scale.

After a fault, the supply capacitor is first allowed to drain to a low restart level. It is then recharged with the reduced current. This stretches the retry period and keeps the energy delivered into a persistent fault very small. A loss of brown-out-OK or thermal-OK is not latched. Switching stops while the condition lasts, and the supply simply cycles between the turn-on and turn-off levels until the flag recovers.

Top module: `startup_supervisor`

## Requirements
- R1: After reset the block is charging. The reduced charge-current select is 0, the PWM enable is 0 and the limit code is 0.
- R2: The start-up source enable is 1 only while charging and only while the high-voltage-above-start flag is 1. It is never 1 while the PWM enable is 1.
- R3: While charging, supply-above-turn-on with brown-out-OK and thermal-OK both 1 sets the PWM enable on the next cycle and clears the source enable in the same cycle.
- R4: While switching, supply-below-turn-off stops the PWM on the next cycle. The source then stays off until supply-below-restart is 1, and the next charge uses the normal current (select 0).
- R5: The limit code is 0 in the first switching cycle. It then rises by one every RAMP_CYCLES/(2^CODE_W-1) switching cycles, holds at 2^CODE_W-1, and restarts from 0 on every entry into switching.
- R6: A fault flag while switching stops the PWM on the next cycle and sets the reduced-current select to 1. The select stays 1 through the following drain and charge. It returns to 0 when switching starts again.
- R7: While switching, brown-out-OK or thermal-OK at 0 stops the PWM on the next cycle without waiting for the restart level. Switching resumes the cycle after both flags are 1 again, as long as supply-below-turn-off is 0.
- R8: Reaching turn-on during charge while brown-out-OK or thermal-OK is 0 does not switch. The block waits with the source off, and recharges at normal current once supply-below-turn-off is 1.
- R9: When several stop conditions arrive in the same switching cycle, the fault wins over turn-off, and turn-off wins over brown-out or thermal loss.
- R10: With the high-voltage-above-start flag at 0, the source enable stays 0 even while charging, so no restart attempt can begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyAboveOn | input | 1 | Supply above turn-on level |
| supplyBelowOff | input | 1 | Supply below turn-off level |
| supplyBelowRestart | input | 1 | Supply below restart level |
| hvAboveStart | input | 1 | High-voltage input above start level |
| brownOk | input | 1 | Brown-out comparator reports OK |
| thermalOk | input | 1 | Thermal comparator reports OK |
| faultFlag | input | 1 | Fault latch set |
| hvSourceEn | output | 1 | Start-up current source enable |
| chargeLow | output | 1 | 1 selects reduced charge current |
| pwmEnable | output | 1 | PWM switching allowed |
| limitCode | output | CODE_W | Soft-start current-limit reference |

## Verification
A behavioural reference model in the bench is compared against all four outputs on every clock. The stimulus covers the following patterns:
- A normal power-up followed by a full ramp, which separates correct step timing and clamping from an off-by-one or a wrap at full scale.
- A supply power-down and a fault stop, which distinguish the normal and reduced charge current and confirm the wait for the restart level.
- Brown-out and thermal interruptions, both during switching and at turn-on, which show that these stops are not latched.
- A low high-voltage input, to check that start-up is inhibited.
- Simultaneous stop conditions, which expose the priority order.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_RUN    = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_IDLE   = 2'd3
  } supvState_t;

  typedef struct packed {
    logic advance;
    logic clear;
  } rampCtl_t;
endpackage

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     supplyAboveOn,
  input  logic     supplyBelowOff,
  input  logic     supplyBelowRestart,
  input  logic     hvAboveStart,
  input  logic     brownOk,
  input  logic     thermalOk,
  input  logic     faultFlag,
  output logic     hvSourceEn,
  output logic     chargeLow,
  output logic     pwmEnable,
  output rampCtl_t rampCtl
);
  supvState_t state, nextState;
  logic faultMode, nextFaultMode;
  logic allOk;

  assign allOk = brownOk && thermalOk;

  always_comb begin
    nextState = state;
    nextFaultMode = faultMode;
    unique case (state)
      ST_CHARGE: begin
        if (supplyAboveOn) begin
          if (allOk) begin
            nextState = ST_RUN;
            nextFaultMode = 1'b0;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_RUN: begin
        if (faultFlag) begin
          nextState = ST_DRAIN;
          nextFaultMode = 1'b1;
        end else if (supplyBelowOff) begin
          nextState = ST_DRAIN;
        end else if (!allOk) begin
          nextState = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (supplyBelowRestart) nextState = ST_CHARGE;
      end
      ST_IDLE: begin
        if (supplyBelowOff) begin
          nextState = ST_CHARGE;
        end else if (allOk) begin
          nextState = ST_RUN;
          nextFaultMode = 1'b0;
        end
      end
      default: nextState = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_CHARGE;
      faultMode <= 1'b0;
    end else begin
      state <= nextState;
      faultMode <= nextFaultMode;
    end
  end

  assign hvSourceEn = (state == ST_CHARGE) && hvAboveStart;
  assign chargeLow = faultMode;
  assign pwmEnable = (state == ST_RUN);
  assign rampCtl.advance = (state == ST_RUN) && (nextState == ST_RUN);
  assign rampCtl.clear = !rampCtl.advance;
endmodule

// File: rtl/supv_ramp.sv
module supv_ramp
  import supv_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int STEP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCtl_t          rampCtl,
  output logic [CODE_W-1:0] limitCode
);
  localparam int PRE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CYCLES - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [PRE_W-1:0] prescale;

  always_ff @(posedge clk) begin
    if (!rstN || rampCtl.clear) begin
      prescale <= '0;
      limitCode <= '0;
    end else if (rampCtl.advance) begin
      if (prescale == PRE_LAST) begin
        prescale <= '0;
        if (limitCode != CODE_MAX) limitCode <= limitCode + 1'b1;
      end else begin
        prescale <= prescale + 1'b1;
      end
    end
  end
endmodule

// File: rtl/startup_supervisor.sv
module startup_supervisor
  import supv_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int RAMP_CYCLES = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyAboveOn,
  input  logic              supplyBelowOff,
  input  logic              supplyBelowRestart,
  input  logic              hvAboveStart,
  input  logic              brownOk,
  input  logic              thermalOk,
  input  logic              faultFlag,
  output logic              hvSourceEn,
  output logic              chargeLow,
  output logic              pwmEnable,
  output logic [CODE_W-1:0] limitCode
);
  localparam int STEPS = (1 << CODE_W) - 1;
  localparam int STEP_RAW = RAMP_CYCLES / STEPS;
  localparam int STEP_CYCLES = (STEP_RAW < 1) ? 1 : STEP_RAW;

  rampCtl_t rampCtl;

  supv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .supplyAboveOn(supplyAboveOn), .supplyBelowOff(supplyBelowOff),
    .supplyBelowRestart(supplyBelowRestart), .hvAboveStart(hvAboveStart),
    .brownOk(brownOk), .thermalOk(thermalOk), .faultFlag(faultFlag),
    .hvSourceEn(hvSourceEn), .chargeLow(chargeLow), .pwmEnable(pwmEnable),
    .rampCtl(rampCtl)
  );

  supv_ramp #(.CODE_W(CODE_W), .STEP_CYCLES(STEP_CYCLES)) u_ramp (
    .clk(clk), .rstN(rstN), .rampCtl(rampCtl), .limitCode(limitCode)
  );
endmodule

// File: rtl/supv_chk.sv
module supv_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              supplyBelowOff,
  input logic              hvAboveStart,
  input logic              brownOk,
  input logic              thermalOk,
  input logic              faultFlag,
  input logic              hvSourceEn,
  input logic              chargeLow,
  input logic              pwmEnable,
  input logic [CODE_W-1:0] limitCode
);
  // R2
  src_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    hvSourceEn |-> (hvAboveStart && !pwmEnable));

  // R3
  start_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmEnable) |-> $past(brownOk && thermalOk));

  // R5
  ramp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmEnable) |-> (limitCode == '0));

  // R5
  ramp_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && $past(pwmEnable)) |-> (limitCode >= $past(limitCode)));

  // R6
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && faultFlag) |=> (!pwmEnable && chargeLow));

  // R7
  env_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && !(brownOk && thermalOk)) |=> !pwmEnable);

  // R4
  off_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && supplyBelowOff) |=> !pwmEnable);
endmodule

bind startup_supervisor supv_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .supplyBelowOff(supplyBelowOff),
  .hvAboveStart(hvAboveStart), .brownOk(brownOk), .thermalOk(thermalOk),
  .faultFlag(faultFlag), .hvSourceEn(hvSourceEn), .chargeLow(chargeLow),
  .pwmEnable(pwmEnable), .limitCode(limitCode)
);

// File: tb/startup_supervisor_test.sv
module startup_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 4;
  localparam int RAMP_CYCLES = 120;
  localparam int STEP = RAMP_CYCLES / ((1 << CODE_W) - 1);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyAboveOn = 1'b0, supplyBelowOff = 1'b1, supplyBelowRestart = 1'b1;
  logic hvAboveStart = 1'b1, brownOk = 1'b1, thermalOk = 1'b1, faultFlag = 1'b0;
  logic hvSourceEn, chargeLow, pwmEnable;
  logic [CODE_W-1:0] limitCode;

  int errors = 0, checks = 0, cycles = 0;
  // model: 0 charge, 1 run, 2 drain, 3 idle
  int mState = 0, mFault = 0, mPre = 0, mCode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  startup_supervisor #(.CODE_W(CODE_W), .RAMP_CYCLES(RAMP_CYCLES)) uut (
    .clk(clk), .rstN(rstN), .supplyAboveOn(supplyAboveOn),
    .supplyBelowOff(supplyBelowOff), .supplyBelowRestart(supplyBelowRestart),
    .hvAboveStart(hvAboveStart), .brownOk(brownOk), .thermalOk(thermalOk),
    .faultFlag(faultFlag), .hvSourceEn(hvSourceEn), .chargeLow(chargeLow),
    .pwmEnable(pwmEnable), .limitCode(limitCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model_update();
    int ns;
    logic ok;
    ns = mState;
    ok = brownOk && thermalOk;
    if (!rstN) begin
      ns = 0; mFault = 0;
    end else begin
      case (mState)
        0: if (supplyAboveOn) begin
             if (ok) begin ns = 1; mFault = 0; end else ns = 3;
           end
        1: if (faultFlag) begin ns = 2; mFault = 1; end
           else if (supplyBelowOff) ns = 2;
           else if (!ok) ns = 3;
        2: if (supplyBelowRestart) ns = 0;
        default: if (supplyBelowOff) ns = 0;
                 else if (ok) begin ns = 1; mFault = 0; end
      endcase
    end
    if (rstN && mState == 1 && ns == 1) begin
      if (mPre == STEP - 1) begin
        mPre = 0;
        if (mCode < CODE_MAX) mCode++;
      end else mPre++;
    end else begin
      mPre = 0; mCode = 0;
    end
    mState = ns;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) begin
      check("watchdog", 1, 0);
      finish_run();
    end
    check({tag, " pwmEnable"}, int'(pwmEnable), int'(mState == 1));
    check({tag, " hvSourceEn"}, int'(hvSourceEn), int'(mState == 0 && hvAboveStart));
    check({tag, " chargeLow"}, int'(chargeLow), mFault);
    check({tag, " limitCode"}, int'(limitCode), mCode);
  endtask

  task automatic steps(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic charge_to_run(input string tag);
    supplyBelowRestart = 1'b0; step(tag);
    supplyBelowOff = 1'b0; step(tag);
    supplyAboveOn = 1'b1; step(tag);
    supplyAboveOn = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    steps("R1", 3);
    rstN = 1'b1;
    // R1: reset state seen at the ports
    check("R1 pwm", int'(pwmEnable), 0);
    check("R1 chargeLow", int'(chargeLow), 0);
    check("R1 code", int'(limitCode), 0);
    check("R1 source", int'(hvSourceEn), 1);

    // R10: low high-voltage input inhibits the source
    hvAboveStart = 1'b0; steps("R10", 3);
    check("R10 source", int'(hvSourceEn), 0);
    hvAboveStart = 1'b1; steps("R2", 3);

    // R3: turn-on
    charge_to_run("R3");
    check("R3 pwm", int'(pwmEnable), 1);
    check("R3 source", int'(hvSourceEn), 0);

    // R5: full ramp and clamp
    steps("R5", 130);
    check("R5 clamp", int'(limitCode), CODE_MAX);

    // R4: power-down, wait for restart level
    supplyBelowOff = 1'b1; steps("R4", 5);
    check("R4 source held off", int'(hvSourceEn), 0);
    supplyBelowRestart = 1'b1; step("R4");
    check("R4 normal current", int'(chargeLow), 0);

    // R5: ramp restarts on the next attempt
    charge_to_run("R5");
    check("R5 restart code", int'(limitCode), 0);
    steps("R5", 2 * STEP + 1);

    // R6: fault then slow retry
    faultFlag = 1'b1; step("R6");
    faultFlag = 1'b0;
    check("R6 low current", int'(chargeLow), 1);
    supplyBelowOff = 1'b1; steps("R6", 3);
    supplyBelowRestart = 1'b1; step("R6");
    check("R6 charging low", int'(hvSourceEn & chargeLow), 1);
    charge_to_run("R6");
    check("R6 cleared", int'(chargeLow), 0);

    // R7: brown-out during switching
    brownOk = 1'b0; steps("R7", 3);
    check("R7 stopped", int'(pwmEnable), 0);
    brownOk = 1'b1; step("R7");
    check("R7 resumed", int'(pwmEnable), 1);

    // R8: thermal loss, recharge, turn-on blocked
    thermalOk = 1'b0; step("R7");
    supplyBelowOff = 1'b1; step("R8");
    check("R8 charging", int'(hvSourceEn), 1);
    supplyBelowOff = 1'b0; supplyAboveOn = 1'b1; step("R8");
    supplyAboveOn = 1'b0; steps("R8", 3);
    check("R8 no switching", int'(pwmEnable), 0);
    thermalOk = 1'b1; step("R8");
    check("R8 resume", int'(pwmEnable), 1);

    // R9: priority between simultaneous stops
    faultFlag = 1'b1; brownOk = 1'b0; supplyBelowOff = 1'b1; step("R9");
    faultFlag = 1'b0; brownOk = 1'b1;
    check("R9 fault wins", int'(chargeLow), 1);
    supplyBelowRestart = 1'b1; step("R9");
    charge_to_run("R9");
    brownOk = 1'b0; supplyBelowOff = 1'b1; step("R9");
    brownOk = 1'b1;
    steps("R9", 2);
    check("R9 off wins over brown-out", int'(hvSourceEn), 0);
    finish_run();
  end
endmodule